// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output-compare channel. It watches one of two external 16-bit timer counts and drives a single output pin. It also raises a one-cycle interrupt pulse whenever its event logic acts. Software sets it up through three 16-bit registers on a simple write and read port:

- a control word at address 0;
- a first match value at address 1;
- a second match value at address 2.

A three-bit mode field picks one of eight behaviours:

- idle (disabled);
- one-way set or clear on a match;
- toggle on a match;
- a single pulse or a repeating pulse, framed by the two match values;
- pulse-width modulation, where the timer's period strobe starts each cycle and a latched duty value ends it.

One of the PWM variants watches an active-low fault input. A fault forces the pin low and sets a status flag that software cannot write. Only a rewrite of the control word releases the pin and clears the flag.

The timers, pin routing and the interrupt controller sit outside the block. Timer counts and their period strobes arrive as inputs. The pin and the interrupt are registered, so both change on the clock edge after the event is seen. A control bit can freeze the channel while the chip-level idle input is high.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the control word, both match registers, the pin, the interrupt and the fault flag are all 0.
- R2: The control word reads back with the idle-stop bit at bit 13, the fault flag at bit 4, the timer select at bit 3 and the mode at bits 2:0, and every other bit reads 0. A write cannot set the fault flag. Addresses 1 and 2 read back the first and second match values.
- R3: On the clock edge that takes a control-word write, the pin becomes 1 if the written mode is 010 and 0 for every other mode. That edge also clears the fault flag and evaluates no event.
- R4: Modes 001 and 010 work as follows:
  - In mode 001, when the count equals the first match value and the pin is low, the pin goes high.
  - In mode 010, when the count equals the first match value and the pin is high, the pin goes low.
  - The interrupt pulses only when the pin changes.
- R5: In mode 011, every cycle in which the count equals the first match value inverts the pin and pulses the interrupt.
- R6: In mode 100, the pin rises (with an interrupt) when the count equals the first match value while low. It falls (with an interrupt) when the count equals the second match value while high. After that fall the channel is inert until the next control-word write.
- R7: Mode 101 behaves like mode 100 but never goes inert, so a pulse is produced every timer cycle.
- R8: Modes 110 and 111 (PWM) work as follows:
  - At each period strobe of the selected timer, the pin goes high, the interrupt pulses, and the second match value is copied into the duty latch.
  - A later cycle where the count equals the latched duty value while the pin is high drives the pin low, with no interrupt.
  - The strobe wins if both happen in one cycle.
- R9: The fault input works as follows:
  - In mode 111, a cycle with the fault input low forces the pin low and sets the fault flag.
  - While the flag is set, the pin stays low and no interrupt is produced.
  - In mode 110 the fault input has no effect.
- R10: Timer select 0 uses timer A's count and strobe, and 1 uses timer B's.
- R11: With the idle-stop bit at 1 and the idle input high, the pin, the interrupt-generating events and the pulse state hold. With the idle-stop bit at 0, the idle input has no effect.
- R12: In mode 000 the pin is low and no interrupt is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 first match, 2 second match) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tmra_cnt | input | 16 | Timer A count |
| tmra_prd | input | 1 | Timer A period strobe |
| tmrb_cnt | input | 16 | Timer B count |
| tmrb_prd | input | 1 | Timer B period strobe |
| idle | input | 1 | Chip idle indication |
| fault_n | input | 1 | Active-low fault input |
| oc_pin | output | 1 | Compare output pin |
| oc_irq | output | 1 | One-cycle interrupt pulse |

## Verification
A bench model steps through every mode while two free-running timers with different periods (20 and 13 counts) run underneath it. The patterns are chosen to separate confusable behaviours:

- One-way set against toggle shows whether a repeated match is ignored or acted on.
- Single pulse against repeating pulse shows whether the one-shot state latches.
- A duty value rewritten in the middle of a period shows whether the PWM duty is latched only at the strobe.
- One-cycle fault pulses in the two PWM modes show that the fault gate is specific to mode 111.
- Switching the timer select shows that the match follows timer B's count and not timer A's.
- Raising idle with the idle-stop bit at 1 and then at 0 tells freezing apart from running on.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [2:0] {
        OCM_OFF  = 3'b000,
        OCM_SET  = 3'b001,
        OCM_CLR  = 3'b010,
        OCM_TGL  = 3'b011,
        OCM_ONE  = 3'b100,
        OCM_REP  = 3'b101,
        OCM_PWM  = 3'b110,
        OCM_PWMF = 3'b111
    } ocm_mode_e;

    typedef struct packed {
        logic      idle_stop;
        logic      tsel;
        ocm_mode_e mode;
    } ocm_ctrl_s;

    localparam int CTL_IDLE_BIT = 13;
    localparam int CTL_FLT_BIT  = 4;
    localparam int CTL_TSEL_BIT = 3;
    localparam int CTL_W        = 16;

    function automatic logic init_level(input ocm_mode_e m);
        return (m == OCM_CLR);
    endfunction

    function automatic logic is_pwm(input ocm_mode_e m);
        return (m == OCM_PWM) || (m == OCM_PWMF);
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctrl(input ocm_ctrl_s c, input logic flt);
        logic [CTL_W-1:0] v;
        v = '0;
        v[CTL_IDLE_BIT] = c.idle_stop;
        v[CTL_FLT_BIT]  = flt;
        v[CTL_TSEL_BIT] = c.tsel;
        v[2:0]          = c.mode;
        return v;
    endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          flt,
    output ocm_ctrl_s     ctrl,
    output logic [DW-1:0] match_a,
    output logic [DW-1:0] match_b,
    output logic          ctrl_wr,
    output ocm_mode_e     wr_mode,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] A_CTRL = AW'(0);
    localparam logic [AW-1:0] A_MA   = AW'(1);
    localparam logic [AW-1:0] A_MB   = AW'(2);

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign wr_mode = ocm_mode_e'(wdata[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            match_a <= '0;
            match_b <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) begin
                ctrl.idle_stop <= wdata[CTL_IDLE_BIT];
                ctrl.tsel      <= wdata[CTL_TSEL_BIT];
                ctrl.mode      <= wr_mode;
            end
            if (addr == A_MA) match_a <= wdata;
            if (addr == A_MB) match_b <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = DW'(pack_ctrl(ctrl, flt));
            A_MA:    rdata = match_a;
            A_MB:    rdata = match_b;
            default: rdata = '0;
        endcase
    end

    // a write to the first match register lands on the next edge
    p_match_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_MA) |=> (match_a == $past(wdata)));

endmodule

// File: rtl/ocmp_tbsel.sv
module ocmp_tbsel #(
    parameter int DW     = 16,
    parameter int NUM_TB = 2
) (
    input  logic                        sel,
    input  logic [NUM_TB-1:0][DW-1:0]   cnt_in,
    input  logic [NUM_TB-1:0]           prd_in,
    output logic [DW-1:0]               cnt,
    output logic                        prd
);
    localparam int SW = (NUM_TB > 1) ? $clog2(NUM_TB) : 1;

    logic [SW-1:0] idx;
    assign idx = SW'(sel);

    generate
        if (NUM_TB == 1) begin : g_single
            assign cnt = cnt_in[0];
            assign prd = prd_in[0];
        end else begin : g_multi
            assign cnt = cnt_in[idx];
            assign prd = prd_in[idx];
        end
    endgenerate

endmodule

// File: rtl/ocmp_engine.sv
module ocmp_engine
    import ocmp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ocm_ctrl_s     ctrl,
    input  logic [DW-1:0] match_a,
    input  logic [DW-1:0] match_b,
    input  logic [DW-1:0] cnt,
    input  logic          prd,
    input  logic          idle,
    input  logic          fault_n,
    input  logic          ctrl_wr,
    input  ocm_mode_e     wr_mode,
    output logic          pin,
    output logic          irq,
    output logic          flt
);
    logic          done;
    logic [DW-1:0] duty;
    logic          frozen, hit_a, hit_b, hit_duty;

    assign frozen   = ctrl.idle_stop && idle;
    assign hit_a    = (cnt == match_a);
    assign hit_b    = (cnt == match_b);
    assign hit_duty = (cnt == duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin  <= 1'b0;
            irq  <= 1'b0;
            flt  <= 1'b0;
            done <= 1'b0;
            duty <= '0;
        end else begin
            irq <= 1'b0;
            if (ctrl_wr) begin
                pin  <= init_level(wr_mode);
                flt  <= 1'b0;
                done <= 1'b0;
            end else if (!frozen) begin
                unique case (ctrl.mode)
                    OCM_OFF: pin <= 1'b0;
                    OCM_SET: if (hit_a && !pin) begin
                        pin <= 1'b1;
                        irq <= 1'b1;
                    end
                    OCM_CLR: if (hit_a && pin) begin
                        pin <= 1'b0;
                        irq <= 1'b1;
                    end
                    OCM_TGL: if (hit_a) begin
                        pin <= !pin;
                        irq <= 1'b1;
                    end
                    OCM_ONE, OCM_REP: if (!done) begin
                        if (hit_a && !pin) begin
                            pin <= 1'b1;
                            irq <= 1'b1;
                        end else if (hit_b && pin) begin
                            pin <= 1'b0;
                            irq <= 1'b1;
                            done <= (ctrl.mode == OCM_ONE);
                        end
                    end
                    OCM_PWM, OCM_PWMF: begin
                        if (ctrl.mode == OCM_PWMF && (flt || !fault_n)) begin
                            pin <= 1'b0;
                            flt <= 1'b1;
                        end else if (prd) begin
                            pin  <= 1'b1;
                            irq  <= 1'b1;
                            duty <= match_b;
                        end else if (hit_duty && pin) begin
                            pin <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    p_fault_pin_low_r9: assert property (@(posedge clk) disable iff (rst)
        flt |-> !pin);
    p_fault_mode_r9: assert property (@(posedge clk) disable iff (rst)
        flt |-> (ctrl.mode == OCM_PWMF));
    p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == OCM_OFF) |-> (!pin && !irq));
    p_irq_changes_pin_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && !is_pwm(ctrl.mode)) |-> (pin != $past(pin)));
    p_pwm_irq_high_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && is_pwm(ctrl.mode)) |-> pin);
    p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        (frozen && !ctrl_wr) |=> ($stable(pin) && !irq));

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] tmra_cnt,
    input  logic          tmra_prd,
    input  logic [DW-1:0] tmrb_cnt,
    input  logic          tmrb_prd,
    input  logic          idle,
    input  logic          fault_n,
    output logic          oc_pin,
    output logic          oc_irq
);
    localparam int NUM_TB = 2;

    ocm_ctrl_s     ctrl;
    ocm_mode_e     wr_mode;
    logic          ctrl_wr, flt, sel_prd;
    logic [DW-1:0] match_a, match_b, sel_cnt;

    ocmp_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .flt(flt), .ctrl(ctrl), .match_a(match_a), .match_b(match_b),
        .ctrl_wr(ctrl_wr), .wr_mode(wr_mode), .rdata(reg_rdata)
    );

    ocmp_tbsel #(.DW(DW), .NUM_TB(NUM_TB)) u_tbsel (
        .sel(ctrl.tsel),
        .cnt_in({tmrb_cnt, tmra_cnt}),
        .prd_in({tmrb_prd, tmra_prd}),
        .cnt(sel_cnt), .prd(sel_prd)
    );

    ocmp_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst(rst), .ctrl(ctrl), .match_a(match_a), .match_b(match_b),
        .cnt(sel_cnt), .prd(sel_prd), .idle(idle), .fault_n(fault_n),
        .ctrl_wr(ctrl_wr), .wr_mode(wr_mode),
        .pin(oc_pin), .irq(oc_irq), .flt(flt)
    );

endmodule

// File: tb/sim_ocmp_channel.sv
`timescale 1ns/1ps
module sim_ocmp_channel;
    localparam int CLK_NS = 8;

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic [15:0] ta = 0, tb = 0;
    logic        idle = 0, fault_n = 1, oc_pin, oc_irq;
    logic        ta_prd, tb_prd;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit cmp_on = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign ta_prd = (ta == 0);
    assign tb_prd = (tb == 0);

    ocmp_channel u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tmra_cnt(ta), .tmra_prd(ta_prd), .tmrb_cnt(tb), .tmrb_prd(tb_prd),
        .idle(idle), .fault_n(fault_n), .oc_pin(oc_pin), .oc_irq(oc_irq)
    );

    // free-running timers, periods 20 and 13
    always @(negedge clk) begin
        if (rst) begin ta <= 0; tb <= 0; end
        else begin
            ta <= (ta == 19) ? 16'd0 : ta + 16'd1;
            tb <= (tb == 12) ? 16'd0 : tb + 16'd1;
        end
    end

    // behavioural reference model
    bit m_sidl, m_tsel, m_flt, m_pin, m_irq, m_done;
    int m_mode, m_a, m_b, m_duty;
    always @(posedge clk) begin
        int c; bit p;
        if (rst) begin
            m_sidl = 0; m_tsel = 0; m_flt = 0; m_pin = 0; m_irq = 0; m_done = 0;
            m_mode = 0; m_a = 0; m_b = 0; m_duty = 0;
        end else begin
            c = m_tsel ? int'(tb) : int'(ta);
            p = m_tsel ? tb_prd : ta_prd;
            m_irq = 0;
            if (reg_wr && reg_addr == 0) begin
                m_sidl = reg_wdata[13]; m_tsel = reg_wdata[3]; m_mode = int'(reg_wdata[2:0]);
                m_flt = 0; m_done = 0; m_pin = (m_mode == 2);
            end else if (!(m_sidl && idle)) begin
                if (m_mode == 0) m_pin = 0;
                else if (m_mode == 1) begin if (c == m_a && !m_pin) begin m_pin = 1; m_irq = 1; end end
                else if (m_mode == 2) begin if (c == m_a && m_pin) begin m_pin = 0; m_irq = 1; end end
                else if (m_mode == 3) begin if (c == m_a) begin m_pin = !m_pin; m_irq = 1; end end
                else if (m_mode == 4 || m_mode == 5) begin
                    if (!m_done) begin
                        if (c == m_a && !m_pin) begin m_pin = 1; m_irq = 1; end
                        else if (c == m_b && m_pin) begin m_pin = 0; m_irq = 1; m_done = (m_mode == 4); end
                    end
                end else begin
                    if (m_mode == 7 && (m_flt || !fault_n)) begin m_pin = 0; m_flt = 1; end
                    else if (p) begin m_pin = 1; m_irq = 1; m_duty = m_b; end
                    else if (c == m_duty && m_pin) m_pin = 0;
                end
            end
            if (reg_wr && reg_addr == 1) m_a = int'(reg_wdata);
            if (reg_wr && reg_addr == 2) m_b = int'(reg_wdata);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (oc_pin !== m_pin || oc_irq !== m_irq) begin
                errors++;
                $display("FAIL %s: pin/irq actual %b/%b expected %b/%b at %0t",
                         cur_req, oc_pin, oc_irq, m_pin, m_irq, $time);
            end
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d actual %h expected %h", req, a, reg_rdata, exp);
        end
        reg_addr = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        rd_chk(0, 16'h0000, "R1");
        rd_chk(1, 16'h0000, "R1");
        rd_chk(2, 16'h0000, "R1");
        checks++;
        if (oc_pin !== 0 || oc_irq !== 0) begin
            errors++; $display("FAIL R1: pin/irq actual %b/%b expected 0/0", oc_pin, oc_irq);
        end
        cmp_on = 1;
        // R2: layout, unimplemented bits and write-protected fault flag
        cur_req = "R2";
        wr_reg(0, 16'hFFFF); rd_chk(0, 16'h200F, "R2");
        wr_reg(0, 16'h001E); rd_chk(0, 16'h000E, "R2");
        wr_reg(1, 16'h1234); rd_chk(1, 16'h1234, "R2");
        wr_reg(2, 16'hBEEF); rd_chk(2, 16'hBEEF, "R2");
        // R12: disabled
        cur_req = "R12"; wr_reg(0, 16'h0000); wr_reg(1, 5); run(45);
        // R4: one-way set and clear
        cur_req = "R4"; wr_reg(0, 16'h0001); run(50);
        cur_req = "R3"; wr_reg(0, 16'h0002); run(2);
        cur_req = "R4"; run(50);
        // R5: toggle
        cur_req = "R5"; wr_reg(1, 7); wr_reg(0, 16'h0003); run(70);
        // R6: single pulse
        cur_req = "R6"; wr_reg(1, 3); wr_reg(2, 10); wr_reg(0, 16'h0004); run(80);
        // R7: continuous pulses
        cur_req = "R7"; wr_reg(0, 16'h0005); run(80);
        // R10: timer B time base
        cur_req = "R10"; wr_reg(1, 4); wr_reg(0, 16'h000B); run(60);
        // R8: PWM with duty change mid-period
        cur_req = "R8"; wr_reg(2, 6); wr_reg(0, 16'h0006); run(45);
        wr_reg(2, 12); run(50);
        // R9: fault ignored in mode 110
        cur_req = "R9"; @(negedge clk); fault_n = 0; @(negedge clk); fault_n = 1; run(30);
        // R9: fault in mode 111
        wr_reg(0, 16'h0007); run(30);
        @(negedge clk); fault_n = 0; @(negedge clk); fault_n = 1; run(45);
        rd_chk(0, 16'h0017, "R9");
        cur_req = "R3"; wr_reg(0, 16'h0007); rd_chk(0, 16'h0007, "R3");
        cur_req = "R9"; run(45);
        // R11: freeze with idle-stop set, run on with it clear
        cur_req = "R11"; wr_reg(1, 7); wr_reg(0, 16'h2003); run(25);
        @(negedge clk); idle = 1; run(45); @(negedge clk); idle = 0; run(30);
        wr_reg(0, 16'h2005); wr_reg(1, 3); @(negedge clk); idle = 1; run(40);
        @(negedge clk); idle = 0; run(40);
        wr_reg(0, 16'h0003); @(negedge clk); idle = 1; run(50); @(negedge clk); idle = 0;
        cur_req = "R3"; wr_reg(0, 16'h0002); run(3);
        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule